// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

A synthesizable behavioural stand-in for a single-cycle-deselect pipelined synchronous SRAM. It is meant to sit opposite a memory controller under test. Every control and address input is sampled on the rising clock edge. Read data then passes through a second, output register, so a read sampled at edge k drives the bus after edge k+1.

An access starts on either of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write inputs. A 2-bit burst counter then steps the two low address bits, either in interleaved order or in linear order. Cycles with no strobe continue the current burst: they advance when the advance input is low and repeat the current address when it is high. Writes go either to the whole word or to the selected byte lanes. The bidirectional data bus is split into an input, an output and a drive enable. A sleep input blocks every access.

The array is small and parameterised (1024 words of 4 lanes × 9 bits by default).

Top module: `sram_burst_model`

## Requirements
- R1: After reset the bus is not driven (dq_drive = 0), and no burst is active.
- R2: A read cycle sampled at rising edge k presents the word at its address on dq_out, with dq_drive = 1, from just after edge k+1 until edge k+2.
- R3: The chip is selected only when ce1_n = 0, ce2 = 1 and ce3_n = 0. A starting strobe with any other combination performs no access, ends the burst, and leaves the bus undriven.
- R4: With burst_interleave = 1, beat n of a burst uses low address bits (start[1:0] XOR n). The upper bits stay those of the start address.
- R5: With burst_interleave = 0, beat n uses low address bits (start[1:0] + n) mod 4.
- R6: A write cycle stores all four lanes in either of two cases: all_wr_n = 0, or all_wr_n = 1 with lane_wr_en_n = 0 and lane_sel_n = 4'b0000.
- R7: With all_wr_n = 1 and lane_wr_en_n = 0, only lane i with lane_sel_n[i] = 0 is stored. Lane i is bits [9i+8:9i]. With both all_wr_n and lane_wr_en_n high, the cycle is a read.
- R8: A no-strobe cycle in an active burst with advance_n = 1 repeats the access at the current burst address.
- R9: A write cycle never causes the bus to be driven. The bus is driven again only by a later read cycle.
- R10: While sleep = 1, no strobe starts an access and no burst continues. Memory and burst state are unchanged, and the bus goes undriven.
- R11: The processor strobe (cpu_strobe_n = 0 with ce1_n = 0) starts a read whatever the write inputs and the controller strobe are. With ce1_n = 1 the processor strobe is ignored.
- R12: A starting strobe resets the beat count to 0. Each no-strobe cycle with advance_n = 0 adds one, and the count wraps to the start address after four beats.
- R13: out_en_n = 1 forces dq_drive low at once, without changing the pipeline contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, taken by a starting strobe |
| ce1_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, read-only, has priority |
| ctl_strobe_n | input | 1 | Controller-side address strobe, read or write |
| advance_n | input | 1 | Burst advance on continuation cycles, active low |
| all_wr_n | input | 1 | Global full-word write, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output-driver enable, active low |
| burst_interleave | input | 1 | 1 selects interleaved order, 0 linear |
| sleep | input | 1 | Blocks all accesses while high |
| dq_in | input | LANES*LANE_W | Write data, sampled at the write cycle's edge |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_drive | output | 1 | Bus drive enable; low means high impedance |

## Verification
A wrong beat count or burst base shows up as a wrong data word two edges after the faulty beat is sampled, so an order or wrap fault appears within one burst. A bad lane mask or write qualification corrupts the array silently until that address is read back. The bench therefore reads every written region again through later bursts. A lost or stuck read-valid or drive stage shows as dq_drive mismatching on the very next cycle. A burst that stays active after a deselect or during sleep shows as unexpected driving or as corrupted words on the following reads.

// File: rtl/sram_burst_pkg.sv
// Shared helpers for the pipelined burst SRAM model.
// Assumes the burst counter is exactly two bits wide.
package sram_burst_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low two address bits for a given beat under the selected order.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] count,
                                               input burst_order_e order);
        logic [1:0] off;
        if (order == ORDER_INTERLEAVE) off = start ^ count;
        else                           off = start + count;
        return off;
    endfunction

endpackage

// File: rtl/sram_cycle_decode.sv
// Cycle decode: turns the sampled strobes, chip enables, sleep and write
// inputs into one access decision for this edge.
// Assumes at most one access per cycle; the processor strobe wins.
module sram_cycle_decode #(
    parameter int LANES = 4
) (
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             sleep,
    input  logic             advance_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             burst_active,
    output logic             start_p,
    output logic             load,
    output logic             stop,
    output logic             cont,
    output logic             step,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic [LANES-1:0] lane_mask
);

    localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

    logic start_c;
    logic selected;
    logic wr_req;
    logic access;

    // Classify the cycle and qualify the write lanes.
    always_comb begin
        start_p   = !sleep && !cpu_strobe_n && !ce1_n;
        start_c   = !sleep && !start_p && !ctl_strobe_n;
        selected  = !ce1_n && ce2 && !ce3_n;
        load      = (start_p || start_c) && selected;
        stop      = (start_p || start_c) && !selected;
        cont      = !sleep && !start_p && !start_c && burst_active;
        step      = cont && !advance_n;
        wr_req    = !all_wr_n || (!lane_wr_en_n && (lane_sel_n != ALL_LANES));
        if (!all_wr_n)          lane_mask = ALL_LANES;
        else if (!lane_wr_en_n) lane_mask = ~lane_sel_n;
        else                    lane_mask = '0;
        access    = load || cont;
        acc_wr    = access && !start_p && wr_req;
        acc_rd    = access && !acc_wr;
    end

endmodule

// File: rtl/sram_burst_ctr.sv
// Burst address generator: holds the start address and a 2-bit beat count,
// and forms the address used by the current cycle's access.
// Assumes ADDR_W >= 3; load, stop and step are mutually exclusive.
module sram_burst_ctr
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              stop,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        burst_cnt,
    output logic              burst_active
);

    localparam int HI = ADDR_W - 1;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;
    logic              act_q;
    burst_order_e      order;

    // Beat count after this cycle and the address it selects.
    always_comb begin
        order  = interleave ? ORDER_INTERLEAVE : ORDER_LINEAR;
        cnt_nx = step ? cnt_q + 2'd1 : cnt_q;
        if (load) acc_addr = addr_in;
        else      acc_addr = {base_q[HI:2], beat_offset(base_q[1:0], cnt_nx, order)};
    end

    // Burst state: start, end and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
            act_q  <= 1'b1;
        end else begin
            if (stop) act_q <= 1'b0;
            cnt_q <= cnt_nx;
        end
    end

    assign burst_cnt    = cnt_q;
    assign burst_active = act_q;

endmodule

// File: rtl/sram_lane_array.sv
// Storage array split into byte lanes with a registered read port.
// Assumes one access per cycle; array contents are not reset.
module sram_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_rd,
    input  logic                    acc_wr,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_valid,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Per-lane write and first read register stage.
        always_ff @(posedge clk) begin
            if (acc_wr && lane_mask[g]) mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            if (acc_rd) rd_q <= mem[acc_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end

    // Marks that the first read stage holds a fresh word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= acc_rd;
    end

endmodule

// File: rtl/sram_out_stage.sv
// Output register and bus driver enable.
// Assumes out_en_n acts asynchronously and only gates the driver.
module sram_out_stage #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              drive_q
);

    logic [WORD_W-1:0] dout_q;

    // Second pipeline stage: capture read data and drive request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            dout_q  <= '0;
        end else begin
            drive_q <= rd_valid;
            if (rd_valid) dout_q <= rd_data;
        end
    end

    assign dq_out   = dout_q;
    assign dq_drive = drive_q && !out_en_n;

endmodule

// File: rtl/sram_burst_model.sv
// Top of the pipelined burst SRAM model: decode, burst counter,
// lane array and output stage in series.
// Assumes the bidirectional bus is split into dq_in, dq_out and dq_drive.
module sram_burst_model #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    advance_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    burst_interleave,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);

    localparam int WORD_W = LANES * LANE_W;

    logic              start_p, load, stop, cont, step, acc_rd, acc_wr;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic [1:0]        burst_cnt;
    logic              burst_active;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;
    logic              drive_q;

    sram_cycle_decode #(.LANES(LANES)) u_decode (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .ce1_n        (ce1_n),
        .ce2          (ce2),
        .ce3_n        (ce3_n),
        .sleep        (sleep),
        .advance_n    (advance_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .burst_active (burst_active),
        .start_p      (start_p),
        .load         (load),
        .stop         (stop),
        .cont         (cont),
        .step         (step),
        .acc_rd       (acc_rd),
        .acc_wr       (acc_wr),
        .lane_mask    (lane_mask)
    );

    sram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .stop         (stop),
        .step         (step),
        .interleave   (burst_interleave),
        .addr_in      (addr),
        .acc_addr     (acc_addr),
        .burst_cnt    (burst_cnt),
        .burst_active (burst_active)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .lane_mask (lane_mask),
        .acc_addr  (acc_addr),
        .wdata     (dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    sram_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .out_en_n (out_en_n),
        .dq_out   (dq_out),
        .dq_drive (dq_drive),
        .drive_q  (drive_q)
    );

endmodule

// File: rtl/sram_burst_chk.sv
// Property checker for the burst SRAM model, bound to the top module.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module sram_burst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep,
    input logic       advance_n,
    input logic       start_p,
    input logic       load,
    input logic       stop,
    input logic       cont,
    input logic       step,
    input logic       acc_rd,
    input logic       acc_wr,
    input logic [1:0] burst_cnt,
    input logic       burst_active,
    input logic       drive_q
);

    p_deselect_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !burst_active);

    p_suspend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && advance_n) |=> $stable(burst_cnt));

    p_write_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> ##1 !drive_q);

    p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !(acc_rd || acc_wr || load));

    p_cpu_reads_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> !acc_wr);

    p_load_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (burst_cnt == 2'd0 && burst_active));

    p_step_adds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (burst_cnt == $past(burst_cnt) + 2'd1));

endmodule

bind sram_burst_model sram_burst_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .advance_n    (advance_n),
    .start_p      (start_p),
    .load         (load),
    .stop         (stop),
    .cont         (cont),
    .step         (step),
    .acc_rd       (acc_rd),
    .acc_wr       (acc_wr),
    .burst_cnt    (burst_cnt),
    .burst_active (burst_active),
    .drive_q      (drive_q)
);

// File: tb/sim_sram_burst_model.sv
`timescale 1ns/1ps
// Bench: behavioural reference of the SRAM, compared on every clock.
module sim_sram_burst_model;

    localparam int AW = 10;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce1_n, ce2, ce3_n, cpu_strobe_n, ctl_strobe_n, advance_n;
    logic          all_wr_n, lane_wr_en_n, out_en_n, burst_interleave, sleep;
    logic [NL-1:0] lane_sel_n;
    logic [WW-1:0] dq_in;
    logic [WW-1:0] dq_out;
    logic          dq_drive;

    sram_burst_model #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .advance_n(advance_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
        .burst_interleave(burst_interleave), .sleep(sleep), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    bad    = 0;
    bit    done   = 0;
    string phase  = "R1";

    // Reference state
    logic [WW-1:0] ref_mem [1024];
    int            m_base = 0, m_cnt = 0;
    bit            m_act = 0;
    bit            s1_v = 0, s2_v = 0;
    logic [WW-1:0] s1_d, s2_d;

    function automatic int beat_lo(int b, int c, bit il);
        return il ? ((b & 3) ^ c) : (((b & 3) + c) % 4);
    endfunction

    // One clock of the reference, using the inputs sampled at this edge.
    task automatic model_step();
        bit sp, sc, sel, acc, wr, rd;
        int a;
        logic [NL-1:0] msk;
        sp  = !sleep && !cpu_strobe_n && !ce1_n;
        sc  = !sleep && !sp && !ctl_strobe_n;
        sel = !ce1_n && ce2 && !ce3_n;
        acc = 0; a = 0;
        if (sp || sc) begin
            if (sel) begin
                m_base = int'(addr); m_cnt = 0; m_act = 1; acc = 1; a = m_base;
            end else m_act = 0;
        end else if (!sleep && m_act) begin
            if (!advance_n) m_cnt = (m_cnt + 1) % 4;
            a = (m_base & ~3) | beat_lo(m_base, m_cnt, burst_interleave);
            acc = 1;
        end
        if (!all_wr_n) msk = '1;
        else if (!lane_wr_en_n) msk = ~lane_sel_n;
        else msk = '0;
        wr = acc && !sp && (msk != '0);
        rd = acc && !wr;
        s2_v = s1_v; s2_d = s1_d;
        s1_v = rd;
        if (rd) s1_d = ref_mem[a];
        if (wr)
            for (int i = 0; i < NL; i++)
                if (msk[i]) ref_mem[a][i*LW +: LW] = dq_in[i*LW +: LW];
    endtask

    task automatic compare();
        bit exp_drv;
        exp_drv = s2_v && !out_en_n;
        checks++;
        if (dq_drive !== exp_drv) begin
            bad++;
            $display("FAIL %s drive actual=%b expected=%b", phase, dq_drive, exp_drv);
        end else if (exp_drv && dq_out !== s2_d) begin
            bad++;
            $display("FAIL %s data actual=%h expected=%h", phase, dq_out, s2_d);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (rst_n) model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        addr = '0; ce1_n = 0; ce2 = 1; ce3_n = 0; cpu_strobe_n = 1; ctl_strobe_n = 1;
        advance_n = 1; all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = '1;
        out_en_n = 0; sleep = 0; dq_in = '0;
    endtask

    task automatic deselect();
        idle(); ctl_strobe_n = 0; ce1_n = 1; tick(); idle();
    endtask

    function automatic logic [WW-1:0] pat(int seed, int beat);
        return {NL{9'(seed * 37 + beat * 5 + 1)}} ^ WW'(beat << 3);
    endfunction

    // Four-beat full-word write started by the controller strobe.
    task automatic burst_write(int a, bit il, int seed);
        idle(); burst_interleave = il; addr = AW'(a); ctl_strobe_n = 0;
        all_wr_n = 0; dq_in = pat(seed, 0); tick();
        for (int b = 1; b < 4; b++) begin
            idle(); burst_interleave = il; advance_n = 0; all_wr_n = 0;
            dq_in = pat(seed, b); tick();
        end
        deselect();
    endtask

    // Read burst with a given number of advancing beats.
    task automatic burst_read(int a, bit il, bit use_cpu, int beats);
        idle(); burst_interleave = il; addr = AW'(a);
        if (use_cpu) cpu_strobe_n = 0; else ctl_strobe_n = 0;
        tick();
        for (int b = 1; b < beats; b++) begin
            idle(); burst_interleave = il; advance_n = 0; tick();
        end
        deselect(); tick(); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", phase);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        idle(); burst_interleave = 1; rst_n = 0;
        tick(); tick();
        rst_n = 1;
        phase = "R1"; tick(); tick();

        // Fill addresses 0..63 with full-word writes (R6)
        phase = "R6";
        for (int k = 0; k < 16; k++) burst_write(k * 4, k[0], k + 3);
        phase = "R2"; burst_read(0, 1, 1, 4);

        // Orders with a mid-group start address (R4, R5)
        phase = "R4"; burst_write(6, 1, 101); burst_read(6, 1, 1, 4); burst_read(9, 1, 0, 4);
        phase = "R5"; burst_write(14, 0, 102); burst_read(14, 0, 1, 4); burst_read(13, 0, 0, 4);
        phase = "R12"; burst_read(18, 0, 1, 7); burst_read(23, 1, 0, 6);

        // Suspend beats (R8)
        phase = "R8";
        idle(); addr = 21; cpu_strobe_n = 0; tick();
        idle(); tick(); tick();
        idle(); advance_n = 0; tick();
        idle(); tick();
        deselect(); tick(); tick();

        // Lane writes (R7) and lane-select-all form of full write (R6)
        phase = "R7";
        idle(); addr = 30; ctl_strobe_n = 0; lane_wr_en_n = 0; lane_sel_n = 4'b1010;
        dq_in = {NL{9'h1A5}}; tick();
        idle(); advance_n = 0; lane_wr_en_n = 0; lane_sel_n = 4'b0111; dq_in = {NL{9'h0F3}}; tick();
        deselect();
        idle(); addr = 33; ctl_strobe_n = 0; dq_in = {NL{9'h155}}; tick();
        deselect(); tick(); tick();
        burst_read(28, 0, 1, 4); burst_read(32, 0, 0, 4);
        phase = "R6";
        idle(); addr = 40; ctl_strobe_n = 0; lane_wr_en_n = 0; lane_sel_n = 4'b0000;
        dq_in = {NL{9'h0C6}}; tick();
        deselect(); burst_read(40, 1, 1, 2);

        // Write leaves the bus undriven (R9)
        phase = "R9";
        burst_read(44, 1, 1, 2);
        idle(); addr = 45; ctl_strobe_n = 0; all_wr_n = 0; dq_in = {NL{9'h1E1}}; tick();
        idle(); all_wr_n = 0; dq_in = {NL{9'h0E2}}; tick(); tick(); tick();
        deselect(); burst_read(44, 1, 1, 4);

        // Deselect combinations (R3)
        phase = "R3";
        idle(); addr = 48; cpu_strobe_n = 0; tick();
        idle(); ctl_strobe_n = 0; ce2 = 0; tick();
        idle(); advance_n = 0; all_wr_n = 0; dq_in = '1; tick(); tick(); tick();
        idle(); cpu_strobe_n = 0; ce3_n = 1; tick();
        idle(); all_wr_n = 0; dq_in = '1; tick(); tick();
        burst_read(48, 1, 0, 4);

        // Processor strobe priority (R11)
        phase = "R11";
        idle(); addr = 52; cpu_strobe_n = 0; ctl_strobe_n = 0; all_wr_n = 0;
        dq_in = '1; tick();
        idle(); advance_n = 0; tick();
        idle(); cpu_strobe_n = 0; ce1_n = 1; advance_n = 0; tick();
        idle(); advance_n = 0; tick();
        deselect(); tick(); tick();
        burst_read(52, 1, 1, 4);

        // Sleep blocks all access (R10)
        phase = "R10";
        deselect();
        idle(); sleep = 1; tick();
        idle(); sleep = 1; addr = 57; ctl_strobe_n = 0; all_wr_n = 0; dq_in = '1; tick();
        idle(); sleep = 1; addr = 58; cpu_strobe_n = 0; tick(); tick();
        idle(); tick(); tick();
        burst_read(56, 0, 1, 4);

        // Output enable gating (R13)
        phase = "R13";
        idle(); addr = 60; cpu_strobe_n = 0; tick();
        idle(); advance_n = 0; tick();
        idle(); advance_n = 0; out_en_n = 1; tick(); tick();
        idle(); advance_n = 0; tick();
        deselect(); tick(); tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule